// File: doc/BRIEF.md
# Forward-Error-Correction Codeword Framer

This block cuts a continuous stream of payload bits into fixed 5440-bit codewords for a forward-error-correction encoder placed after it. The first 5140 bits of every codeword are payload, taken in arrival order. The last 300 bits are driven as zero so that the encoder can later write parity over them. Codewords leave on a transmit bus least-significant bit first. Bit 0 of each codeword always lands on bus bit 0 of the beat that starts it, and a start strobe marks that beat.

A static mode input picks the bus shape. With one lane, each beat carries 160 bits and a codeword takes 34 beats. With two lanes, each beat carries 320 bits, lane 0 in the low half and sent first, and a codeword takes 17 beats. The payload of a codeword is not a whole number of beats. A residual buffer therefore carries leftover payload bits across codeword boundaries, and the input is held off while the buffer already holds enough bits. Both sides use valid/ready handshakes.

Top module: `fec_cw_framer`

## Requirements
- R1: Payload bits fill codeword positions 0 to 5139 in arrival order. Input bit 0 of a word is taken before its bit 1, and codeword position p of beat b sits on out_data bit p minus b times the beat width.
- R2: Codeword positions 5140 to 5439 are always output as zero.
- R3: With dual_mode low, each beat carries 160 codeword bits on out_data[159:0]. out_data[319:160] is zero, and a codeword spans 34 beats.
- R4: With dual_mode high, each beat carries 320 codeword bits on out_data[319:0], with lane 0 (bits 159:0) first. A codeword spans 17 beats.
- R5: out_sop is high, together with out_valid, exactly on the beat that carries codeword position 0, and it is low on every other beat.
- R6: With dual_mode low, in_data[319:160] is ignored. Only in_data[159:0] supplies payload, 160 bits per accepted word.
- R7: No payload bit is lost or duplicated under any pattern of in_valid and out_ready stalls. While out_valid is high and out_ready is low, out_data and out_sop hold steady.
- R8: A synchronous reset empties the residual buffer and the beat position. After reset, out_valid is low and in_ready is high. The first beat produced afterwards is a codeword start, built from the payload that arrives after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dual_mode | input | 1 | 0: one 160-bit lane; 1: two lanes, 320 bits per beat; change only during reset |
| in_data | input | 320 | Payload word, bit 0 first in time |
| in_valid | input | 1 | Payload word present |
| in_ready | output | 1 | Payload word accepted this cycle when in_valid is also high |
| out_data | output | 320 | Codeword beat, bit 0 first in time |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_sop | output | 1 | Beat carries codeword position 0 |

## Verification
The bench runs both bus shapes with four stall patterns: no stalls, a starved input, a slow output, and both sides stalled at random. Each beat is compared with a codeword built arithmetically from a pseudo-random payload. The unstalled runs expose errors in beat width, lane placement and payload-to-parity boundary placement. The stalled runs expose bits dropped or repeated around the residual buffer and around the pure-parity beat. In single-lane runs the bench drives random junk on the upper input half, so leakage of those bits becomes visible. Runs that stop in the middle of a codeword and are then reset show whether the buffer and beat position restart cleanly.

// File: rtl/fec_cw_framer.sv
module fec_cw_framer #(
  parameter int LANE_W  = 160,
  parameter int CW_LEN  = 5440,
  parameter int PAR_LEN = 300
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dual_mode,
  input  logic [2*LANE_W-1:0] in_data,
  input  logic                in_valid,
  output logic                in_ready,
  output logic [2*LANE_W-1:0] out_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_sop
);
  localparam int BUS_W   = 2 * LANE_W;
  localparam int PAY_LEN = CW_LEN - PAR_LEN;
  localparam int BEATS_1 = CW_LEN / LANE_W;
  localparam int BEATS_2 = CW_LEN / BUS_W;
  localparam int BUF_W   = 2 * BUS_W;
  localparam int CNT_W   = $clog2(BUF_W + 1);
  localparam int BEAT_W  = $clog2(BEATS_1);

  logic [BUF_W-1:0]  sbuf;
  logic [CNT_W-1:0]  cnt, wid, need, take, rem;
  logic [BEAT_W-1:0] beat, last_beat;
  logic [BUS_W-1:0]  keep, in_word;
  logic              out_fire, in_fire;
  int                base;

  assign wid       = dual_mode ? CNT_W'(BUS_W) : CNT_W'(LANE_W);
  assign last_beat = dual_mode ? BEAT_W'(BEATS_2 - 1) : BEAT_W'(BEATS_1 - 1);

  always_comb begin
    base = int'(beat) * int'(wid);
    if (base >= PAY_LEN)             need = '0;
    else if (PAY_LEN - base >= wid)  need = wid;
    else                             need = CNT_W'(PAY_LEN - base);
  end

  assign out_valid = cnt >= need;
  assign out_fire  = out_valid && out_ready;
  assign take      = out_fire ? need : '0;
  assign rem       = cnt - take;
  assign in_ready  = (cnt < need) || (out_ready && (cnt - need < wid));
  assign in_fire   = in_valid && in_ready;

  assign keep     = ~({BUS_W{1'b1}} << need);
  assign out_data = sbuf[BUS_W-1:0] & keep;
  assign out_sop  = out_valid && (beat == '0);
  assign in_word  = dual_mode ? in_data : {{LANE_W{1'b0}}, in_data[LANE_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sbuf <= '0;
      cnt  <= '0;
      beat <= '0;
    end else begin
      sbuf <= (sbuf >> take) |
              (in_fire ? ({{(BUF_W-BUS_W){1'b0}}, in_word} << rem) : '0);
      cnt  <= rem + (in_fire ? wid : '0);
      if (out_fire) beat <= (beat == last_beat) ? '0 : beat + 1'b1;
    end
  end

  logic [BEAT_W:0] since;
  logic            seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (out_fire) begin
      if (out_sop) begin
        since <= 1;
        seen  <= 1'b1;
      end else begin
        since <= since + 1'b1;
      end
    end
  end

  // R5
  sop_period_chk: assert property (@(posedge clk) disable iff (rst)
    out_fire && out_sop && seen |->
      since == (dual_mode ? (BEAT_W+1)'(BEATS_2) : (BEAT_W+1)'(BEATS_1)));
  // R7
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(BUF_W));
  // R8
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && in_ready);
  // R3
  lane_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !dual_mode && out_valid |-> out_data[BUS_W-1:LANE_W] == '0);
endmodule

// File: tb/sim_fec_cw_framer.sv
module sim_fec_cw_framer;
  localparam int CLK_T = 10;
  localparam int LW    = 160;
  localparam int BW    = 320;
  localparam int PAY   = 5140;
  localparam int CWL   = 5440;

  logic clk = 0, rst = 1, dual_mode = 0, in_valid = 0, out_ready = 0;
  logic [BW-1:0] in_data = '0;
  logic in_ready, out_valid, out_sop;
  logic [BW-1:0] out_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  fec_cw_framer u0 (.clk(clk), .rst(rst), .dual_mode(dual_mode), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop));

  function automatic logic pbit(int g);
    int unsigned h = unsigned'(g) * 32'h9E3779B1;
    return h[16] ^ h[27] ^ h[5];
  endfunction

  task automatic check(bit ok, string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic make_word(int k, bit dm);
    int w = dm ? BW : LW;
    for (int j = 0; j < BW; j++)
      in_data[j] = (j < w) ? pbit(k * w + j) : 1'($urandom_range(0, 1));
  endtask

  task automatic run_phase(bit dm, int pin, int pout, int nbeats);
    int k = 0, b = 0, c = 0, seen = 0;
    int w = dm ? BW : LW;
    int nb = CWL / w;
    logic [BW-1:0] pay_exp, pay_msk, zmsk;
    @(negedge clk);
    rst = 1; in_valid = 0; out_ready = 0; dual_mode = dm;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R8 reset state
    check(!out_valid && in_ready && !out_sop, "R8 reset state",
          {out_valid, in_ready, out_sop}, 3'b010);
    while (seen < nbeats) begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 99) < pout);
      in_valid  = ($urandom_range(0, 99) < pin);
      make_word(k, dm);
      #1;
      if (in_valid && in_ready) k++;
      if (out_valid && out_ready) begin
        pay_exp = '0; pay_msk = '0; zmsk = '0;
        for (int i = 0; i < BW; i++) begin
          int pos = b * w + i;
          if (i < w && pos < PAY) begin
            pay_msk[i] = 1'b1;
            pay_exp[i] = pbit(c * PAY + pos);
          end else zmsk[i] = 1'b1;
        end
        // R1 payload order, R3 or R4 by lane mode, R6 junk upper input
        check((out_data & pay_msk) == pay_exp, dm ? "R1 R4 R7 payload" : "R1 R3 R6 R7 payload",
              out_data & pay_msk, pay_exp);
        // R2 parity zero, R3 upper lane idle
        check((out_data & zmsk) == '0, "R2 R3 zero region", out_data & zmsk, '0);
        // R5 start strobe
        check(out_sop == (b == 0), "R5 sop", BW'(out_sop), BW'(b == 0));
        seen++;
        b++;
        if (b == nb) begin b = 0; c++; end
      end
    end
  endtask

  initial begin
    run_phase(0, 100, 100, 70);
    run_phase(0, 55, 100, 68);
    run_phase(0, 100, 45, 68);
    run_phase(0, 50, 60, 40);
    run_phase(1, 100, 100, 36);
    run_phase(1, 55, 100, 34);
    run_phase(1, 100, 45, 34);
    run_phase(1, 50, 60, 25);
    run_phase(0, 70, 70, 36);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule